// File: doc/BRIEF.md
# Status-Driven Burst Length Limiter

This block caps the length of each burst that a channelized transmit scheduler sends toward a receiver. The receiver reports the fill state of its per-channel buffer: starving, hungry or satisfied. A table with one byte per channel holds two 4-bit limits. One applies when the receiver is hungry and the other when it is starving. Each limit field value f stands for (f + 1) x 16 bytes.

The scheduler presents one beat per cycle. Each beat carries the channel, the status that the receiver currently reports for that channel, the number of bytes in the beat, and an end-of-packet mark. On the first beat of a burst the block chooses and latches the limit. It then adds up the bytes and raises a burst-end request, in the same cycle, on the beat that reaches or passes the limit or that ends the packet. A satisfied receiver grants no burst, so a beat offered while idle is refused. Software reads and writes the table through a simple byte-wide port. A sticky flag records any write that sets the starving limit below the hungry limit.

Top module: `burst_limiter`

## Requirements
- R1: The table has 64 entries. A write with `cfg_we` high stores `cfg_wdata` at `cfg_addr` on the clock edge, and `cfg_rdata` shows the stored byte at `cfg_addr` combinationally.
- R2: After reset every entry reads 0xFF, `cfg_err` is 0, `burst_active` is 0 and `burst_limit` is 0.
- R3: The hungry field is entry bits 3:0 and the starving field is entry bits 7:4. Status code 2'b01 (hungry) selects the hungry field and code 2'b00 (starving) selects the starving field. The limit in bytes is (field + 1) x 16.
- R4: Status codes 2'b10 (satisfied) and 2'b11 grant a zero limit. A beat offered while idle with such a status raises `beat_reject`, does not raise `burst_end`, and leaves the block idle.
- R5: The limit is latched on the first beat of a burst and shown on `burst_limit` while the burst is open. Later beats ignore `beat_chan`, `beat_status` and table writes.
- R6: `burst_end` is high, in the beat's own cycle, on the accepted beat whose running byte total reaches or passes the latched limit.
- R7: `burst_end` is also high on an accepted beat with `beat_eop` high, even below the limit. After any burst end the block is idle and the next beat starts a new burst.
- R8: A write whose bits 7:4 are smaller than its bits 3:0 sets `cfg_err`, which stays set until reset. The write is still stored. Equal fields do not set `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 6 | Table entry index for both read and write |
| cfg_wdata | input | 8 | Byte to store |
| cfg_rdata | output | 8 | Stored byte at `cfg_addr` |
| cfg_err | output | 1 | Sticky flag for a starving limit programmed below the hungry limit |
| beat_valid | input | 1 | A beat is offered this cycle |
| beat_chan | input | 6 | Channel of the beat (used on the first beat only) |
| beat_status | input | 2 | Receiver status: 00 starving, 01 hungry, 10/11 satisfied |
| beat_bytes | input | 5 | Bytes carried by this beat |
| beat_eop | input | 1 | Beat closes a packet |
| burst_end | output | 1 | Close the burst after this beat |
| beat_reject | output | 1 | Idle beat refused because the limit is zero |
| burst_active | output | 1 | A burst is open |
| burst_limit | output | 9 | Latched limit of the open burst in bytes, 0 when idle |

## Verification
The bench runs beats whose sizes do not divide the limit. A design that tests for exact equality, or that counts the crossing beat late, would let the burst run past its limit. It changes the status and the channel in the middle of a burst, and it rewrites the active entry there too. A design that looks the limit up again on every beat would then move its end point. Idle beats offered under a satisfied status must be refused without opening a burst; a design that lets them through would end a zero-length burst at once. The table writes include equal fields, fields in the wrong order and the extreme values 0 and 15. These catch an error flag that clears itself, fires on equality or drops the write, and any slip in the (f + 1) x 16 scaling at either end of its range.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int FIELD_W    = 4;
  localparam int GRAN_BYTES = 16;
  localparam int ENT_W      = 2 * FIELD_W;
  localparam int MAX_LIM    = (2 ** FIELD_W) * GRAN_BYTES;
  localparam int LIM_W      = $clog2(MAX_LIM + 1);

  typedef enum logic [1:0] {
    ST_STARVING  = 2'b00,
    ST_HUNGRY    = 2'b01,
    ST_SATISFIED = 2'b10,
    ST_RSVD      = 2'b11
  } fifo_st_t;

  // (field + 1) * granule, in bytes
  function automatic logic [LIM_W-1:0] field_to_bytes(input logic [FIELD_W-1:0] f);
    return LIM_W'((int'(f) + 1) * GRAN_BYTES);
  endfunction

  // starving field below hungry field is an illegal setting
  function automatic logic order_bad(input logic [ENT_W-1:0] e);
    return e[ENT_W-1:FIELD_W] < e[FIELD_W-1:0];
  endfunction
endpackage

// File: rtl/bl_desc_table.sv
module bl_desc_table
  import bl_pkg::*;
#(
  parameter int NCH  = 64,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CH_W-1:0]   addr,
  input  logic [ENT_W-1:0]  wdata,
  output logic [ENT_W-1:0]  rdata,
  input  logic [CH_W-1:0]   lk_addr,
  output logic [ENT_W-1:0]  lk_data,
  output logic              err
);
  logic [ENT_W-1:0] mem_q [NCH];
  logic             err_q;
  logic             bad_write;

  assign bad_write = we && order_bad(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) mem_q[i] <= '1;
      err_q <= 1'b0;
    end else begin
      if (we) mem_q[addr] <= wdata;
      if (bad_write) err_q <= 1'b1;
    end
  end

  assign rdata   = mem_q[addr];
  assign lk_data = mem_q[lk_addr];
  assign err     = err_q;

  // R8: the error flag never clears outside reset
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R8: a misordered write is flagged on the next cycle
  a_r8_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    bad_write |=> err_q);
  // R1: a write is visible on the read port next cycle at the same address
  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/bl_limit_sel.sv
module bl_limit_sel
  import bl_pkg::*;
(
  input  logic [ENT_W-1:0] entry,
  input  logic [1:0]       status,
  output logic [LIM_W-1:0] lim,
  output logic             allow
);
  always_comb begin
    unique case (fifo_st_t'(status))
      ST_STARVING: lim = field_to_bytes(entry[ENT_W-1:FIELD_W]);
      ST_HUNGRY:   lim = field_to_bytes(entry[FIELD_W-1:0]);
      default:     lim = '0;
    endcase
  end
  assign allow = (lim != '0);
endmodule

// File: rtl/bl_burst_ctr.sv
module bl_burst_ctr
  import bl_pkg::*;
#(
  parameter int BB_W = 5,
  localparam int CNT_W = $clog2(MAX_LIM + 2 ** BB_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_valid,
  input  logic [BB_W-1:0]  beat_bytes,
  input  logic             beat_eop,
  input  logic [LIM_W-1:0] new_lim,
  input  logic             allow,
  output logic             burst_end,
  output logic             beat_reject,
  output logic             active,
  output logic [LIM_W-1:0] held_lim
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LIM_W-1:0] lim_q;

  logic             take;
  logic [LIM_W-1:0] eff_lim;
  logic [CNT_W-1:0] sum;
  logic             reach;

  assign take        = beat_valid && (active_q || allow);
  assign beat_reject = beat_valid && !active_q && !allow;
  assign eff_lim     = active_q ? lim_q : new_lim;
  assign sum         = (active_q ? cnt_q : '0) + CNT_W'(beat_bytes);
  assign reach       = (sum >= CNT_W'(eff_lim));
  assign burst_end   = take && (reach || beat_eop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      lim_q    <= '0;
    end else if (take) begin
      if (burst_end) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
        lim_q    <= '0;
      end else begin
        active_q <= 1'b1;
        cnt_q    <= sum;
        lim_q    <= eff_lim;
      end
    end
  end

  assign active   = active_q;
  assign held_lim = lim_q;

  // R6: an open burst has always stayed below its limit
  a_r6_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < CNT_W'(lim_q)));
  // R5: the latched limit does not move while the burst stays open
  a_r5_limit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !burst_end) |=> $stable(lim_q));
  // R4: refusal only happens while idle, and never together with an end
  a_r4_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
    beat_reject |-> (!active_q && !burst_end));
  // R4: a refused beat leaves the block idle
  a_r4_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    beat_reject |=> !active_q);
  // R7: after a burst end the block is idle
  a_r7_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> !active_q);
  // R5: an open burst carries a nonzero limit
  a_r5_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (lim_q != '0));
endmodule

// File: rtl/burst_limiter.sv
module burst_limiter
  import bl_pkg::*;
#(
  parameter int NCH  = 64,
  parameter int BB_W = 5,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_addr,
  input  logic [ENT_W-1:0]  cfg_wdata,
  output logic [ENT_W-1:0]  cfg_rdata,
  output logic              cfg_err,
  input  logic              beat_valid,
  input  logic [CH_W-1:0]   beat_chan,
  input  logic [1:0]        beat_status,
  input  logic [BB_W-1:0]   beat_bytes,
  input  logic              beat_eop,
  output logic              burst_end,
  output logic              beat_reject,
  output logic              burst_active,
  output logic [LIM_W-1:0]  burst_limit
);
  logic [ENT_W-1:0] lk_entry;
  logic [LIM_W-1:0] cand_lim;
  logic             cand_allow;

  bl_desc_table #(.NCH(NCH)) u_tab (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .lk_addr (beat_chan),
    .lk_data (lk_entry),
    .err     (cfg_err)
  );

  bl_limit_sel u_sel (
    .entry  (lk_entry),
    .status (beat_status),
    .lim    (cand_lim),
    .allow  (cand_allow)
  );

  bl_burst_ctr #(.BB_W(BB_W)) u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat_valid  (beat_valid),
    .beat_bytes  (beat_bytes),
    .beat_eop    (beat_eop),
    .new_lim     (cand_lim),
    .allow       (cand_allow),
    .burst_end   (burst_end),
    .beat_reject (beat_reject),
    .active      (burst_active),
    .held_lim    (burst_limit)
  );

  // R3: a starting burst under hungry/starving latches a multiple of the granule
  a_r3_granule: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !burst_active && !burst_end && beat_status[1] == 1'b0)
      |=> (burst_limit[3:0] == 4'd0 && burst_limit != '0));
  // R7: end-of-packet on an accepted beat always closes the burst
  a_r7_eop_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_eop && !beat_reject) |-> burst_end);
endmodule

// File: tb/sim_burst_limiter.sv
module sim_burst_limiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       cfg_err;
  logic       beat_valid = 1'b0;
  logic [5:0] beat_chan = '0;
  logic [1:0] beat_status = '0;
  logic [4:0] beat_bytes = '0;
  logic       beat_eop = 1'b0;
  logic       burst_end, beat_reject, burst_active;
  logic [8:0] burst_limit;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench model
  int tab [64];
  bit m_err = 0;
  bit m_act = 0;
  int m_cnt = 0;
  int m_lim = 0;

  always #2 clk = ~clk;

  burst_limiter u0 (.*);

  function automatic int lim_of(input int e, input int st);
    if (st == 1) return 16 + 16 * (e % 16);
    if (st == 0) return 16 + 16 * (e / 16);
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int d);
    @(negedge clk);
    beat_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = 6'(ch); cfg_wdata = 8'(d);
    @(posedge clk);
    tab[ch] = d;
    if ((d / 16) < (d % 16)) m_err = 1;
    #1;
    cfg_we = 1'b0;
    #1;
    chk("R1 readback", cfg_rdata, d);
    chk("R8 err flag", cfg_err, m_err);
  endtask

  task automatic beat(input int ch, input int st, input int nb, input bit eop, input string tag);
    int lim, sum;
    bit e_end, e_rej;
    @(negedge clk);
    beat_valid = 1'b1; beat_chan = 6'(ch); beat_status = 2'(st);
    beat_bytes = 5'(nb); beat_eop = eop;
    #1;
    e_rej = 0; e_end = 0;
    if (!m_act) begin
      lim = lim_of(tab[ch], st);
      sum = nb;
      if (lim == 0) e_rej = 1;
    end else begin
      lim = m_lim;
      sum = m_cnt + nb;
    end
    if (!e_rej) e_end = (sum >= lim) || eop;
    chk({tag, " burst_end"}, burst_end, e_end);
    chk({tag, " beat_reject"}, beat_reject, e_rej);
    @(posedge clk);
    if (!e_rej) begin
      if (e_end) begin m_act = 0; m_cnt = 0; m_lim = 0; end
      else begin m_act = 1; m_cnt = sum; m_lim = lim; end
    end
    #1;
    chk({tag, " R5 active"}, burst_active, m_act);
    chk({tag, " R5 limit"}, burst_limit, m_lim);
  endtask

  task automatic idle();
    @(negedge clk);
    beat_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) tab[i] = 255;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R2 reset state
    chk("R2 active", burst_active, 0);
    chk("R2 limit", burst_limit, 0);
    chk("R2 err", cfg_err, 0);
    for (int i = 0; i < 64; i++) begin
      cfg_addr = 6'(i); #0.1;
      chk("R2 entry", cfg_rdata, 8'hFF);
    end

    // R3 default entry: 256 bytes under starving, with 16-byte beats
    for (int i = 0; i < 16; i++) beat(9, 0, 16, 0, "R3 max starving");

    // R3/R6 field 3 hungry -> 64 bytes, field 7 starving -> 128 bytes
    wr(5, 8'h73);
    for (int i = 0; i < 4; i++) beat(5, 1, 16, 0, "R6 hungry 64");
    for (int i = 0; i < 8; i++) beat(5, 0, 16, 0, "R6 starving 128");
    // R6 crossing: 10-byte beats end on the seventh
    for (int i = 0; i < 7; i++) beat(5, 1, 10, 0, "R6 cross");

    // R4 satisfied and reserved codes refuse idle beats
    beat(5, 2, 8, 0, "R4 satisfied");
    beat(5, 3, 8, 1, "R4 reserved");

    // R5 status, channel and table change mid-burst are ignored
    beat(5, 1, 16, 0, "R5 start");
    beat(20, 2, 16, 0, "R5 status swap");
    wr(5, 8'hFF);
    beat(5, 0, 16, 0, "R5 after write");
    beat(5, 0, 16, 0, "R5 end");

    // R7 end of packet below limit, then new burst
    beat(5, 0, 4, 0, "R7 first");
    beat(5, 0, 4, 1, "R7 eop");
    beat(5, 1, 4, 1, "R7 single eop");

    // R3 minimum field: 16 bytes
    wr(7, 8'h00);
    beat(7, 1, 15, 0, "R3 min a");
    beat(7, 1, 1, 0, "R3 min b");
    beat(7, 0, 17, 0, "R3 min over");

    // R8 equal fields do not flag, misordered does, write kept
    wr(8, 8'h55);
    chk("R8 equal no err", cfg_err, 0);
    wr(8, 8'h37);
    chk("R8 misorder err", cfg_err, 1);
    beat(8, 1, 31, 0, "R8 stored hungry");
    beat(8, 1, 31, 0, "R8 stored hungry b");
    beat(8, 1, 31, 0, "R8 stored hungry c");
    wr(8, 8'hF0);
    chk("R8 sticky", cfg_err, 1);
    idle();

    // random mix
    for (int it = 0; it < 3000; it++) begin
      int r = $urandom_range(0, 15);
      if (r == 0) wr($urandom_range(0, 63), $urandom_range(0, 255));
      else if (r == 1) idle();
      else beat($urandom_range(0, 63), $urandom_range(0, 3), $urandom_range(0, 20),
                ($urandom_range(0, 9) == 0), "R6 random");
    end
    idle();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule